// File: doc/BRIEF.md
# SDRAM Refresh Sequencer

This block sits inside a memory bus controller. It drives the SDRAM command pins only while a refresh is under way. When the refresh-enable control is set and the mode control is clear, a programmable interval down-counter raises a refresh request. The request stays pending until the main access engine reports that it is idle. The sequencer then claims the bus, precharges every bank, waits a programmable idle gap and issues an auto-refresh. It holds the bus for a programmable recovery window and then hands the bus back.

When both controls are set, the same precharge-all prologue runs. It ends in a self-refresh entry command, and clock-enable falls. The memory stays in self-refresh, and the bus stays claimed, until the mode control is cleared. Clock-enable then rises, and no command is issued during the recovery window. Periodic auto-refresh resumes afterwards only if refresh stays enabled. Both timing fields are two bits wide and count one more idle cycle than their value.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Pin codes, written as {csN,rasN,casN,weN}: NOP is 0111, precharge-all is 0010 with addrA10 high, auto-refresh is 0001 with cke high, and self-refresh entry is 0001 with cke low. After reset the outputs show NOP, cke high and memBusy low.
- R2: While refEnable=1 and refMode=0, a refresh request is raised every refInterval cycles (refInterval >= 1). The first request comes refInterval cycles after auto-refresh becomes enabled.
- R3: A pending request, or a self-refresh request, is granted only on a cycle where accessIdle=1. memBusy rises on the next cycle with NOP on the pins, and precharge-all follows one cycle later when no bank is busy.
- R4: While bankBusy=1 after a grant, precharge-all is withheld and NOP is issued. Precharge-all is issued on the cycle after bankBusy is seen low.
- R5: After precharge-all, exactly tPreSel+1 NOP cycles pass before auto-refresh or self-refresh entry is issued.
- R6: After auto-refresh, exactly tRecSel+1 NOP cycles pass with memBusy high. memBusy then falls.
- R7: Self-refresh is entered only when refEnable=1 and refMode=1. refMode=1 alone starts nothing.
- R8: From the self-refresh entry command until exit, cke stays low, the pins show NOP and memBusy stays high.
- R9: Clearing refMode during self-refresh raises cke on the next cycle. From that cycle, tRecSel+1 NOP cycles with memBusy high pass before memBusy falls.
- R10: After self-refresh exit, auto-refresh requests restart from a full interval if refEnable=1. No refresh occurs if refEnable=0.
- R11: Whenever memBusy is low, the pins show NOP and cke is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refEnable | input | 1 | Refresh enable control |
| refMode | input | 1 | Self-refresh select control |
| tPreSel | input | 2 | Idle cycles after precharge-all, minus one |
| tRecSel | input | 2 | Recovery cycles after refresh or exit, minus one |
| refInterval | input | 16 | Cycles between auto-refresh requests |
| accessIdle | input | 1 | Access engine has no transfer in flight |
| bankBusy | input | 1 | A bank is still completing its own precharge |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |
| addrA10 | output | 1 | Address bit 10, high for precharge-all |
| cke | output | 1 | SDRAM clock enable |
| memBusy | output | 1 | Refresh owns the SDRAM; access engine must wait |

## Verification
The embedded properties watch, on every cycle, the rules that hold pin to pin. Precharge-all never follows a busy bank. A refresh command is always preceded by an idle cycle. Low clock-enable never occurs without memBusy, the pins stay quiet whenever memBusy is low, and the bus is only claimed after an idle access engine. The exact lengths of the programmed gaps, the interval between requests, the deferral while the access engine is active, and whether auto-refresh resumes after self-refresh exit only show up in the bench's directed scenarios. Those scenarios count cycles against the field values.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REF  = 2'd2
  } cmdSel_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_PALL = 3'd2,
    ST_TRP  = 3'd3,
    ST_REF  = 3'd4,
    ST_SELF = 3'd5,
    ST_SR   = 3'd6,
    ST_TRC  = 3'd7
  } seqState_e;

  typedef struct packed {
    logic    loadPre;
    logic    loadRec;
    logic    takeReq;
    cmdSel_e cmd;
    logic    ckeLow;
  } dpStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_PALL = 4'b0010;
  localparam logic [3:0] PIN_REF  = 4'b0001;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import sdram_refresh_pkg::*;
#(
  parameter int INTW = 16,
  parameter int TW   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refEnable,
  input  logic            refMode,
  input  logic [TW-1:0]   tPreSel,
  input  logic [TW-1:0]   tRecSel,
  input  logic [INTW-1:0] refInterval,
  input  dpStrobe_t       strobe,
  output logic            reqPending,
  output logic            delayDone,
  output logic            csN,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic            addrA10,
  output logic            cke
);

  localparam int DW = TW + 1;

  logic [INTW-1:0] ivlCnt;
  logic [DW-1:0]   dlyCnt;
  logic            autoEn;
  logic            ivlTick;
  logic [3:0]      pinCode;

  assign autoEn  = refEnable & ~refMode;
  assign ivlTick = autoEn && (ivlCnt <= INTW'(1));

  // interval down-counter: reloads while auto-refresh is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  ivlCnt <= '1;
    else if (!autoEn || ivlTick) ivlCnt <= refInterval;
    else                         ivlCnt <= ivlCnt - 1'b1;
  end

  // request held until granted; a fresh tick wins over a grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               reqPending <= 1'b0;
    else if (!refEnable)     reqPending <= 1'b0;
    else if (ivlTick)        reqPending <= 1'b1;
    else if (strobe.takeReq) reqPending <= 1'b0;
  end

  // shared idle-gap counter for precharge wait and recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dlyCnt <= '0;
    else if (strobe.loadPre) dlyCnt <= DW'(tPreSel) + DW'(1);
    else if (strobe.loadRec) dlyCnt <= DW'(tRecSel) + DW'(1);
    else if (dlyCnt != '0)   dlyCnt <= dlyCnt - 1'b1;
  end

  assign delayDone = (dlyCnt == DW'(1));

  always_comb begin
    case (strobe.cmd)
      CMD_PALL: pinCode = PIN_PALL;
      CMD_REF:  pinCode = PIN_REF;
      default:  pinCode = PIN_NOP;
    endcase
  end

  assign {csN, rasN, casN, weN} = pinCode;
  assign addrA10 = (strobe.cmd == CMD_PALL);
  assign cke     = ~strobe.ckeLow;

  p_gap_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    dlyCnt <= DW'(1 << TW))
    else $error("idle-gap counter exceeds its field range");

  p_pending_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqPending |-> $past(refEnable))
    else $error("request pending without refresh enabled");

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import sdram_refresh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refEnable,
  input  logic      refMode,
  input  logic      accessIdle,
  input  logic      bankBusy,
  input  logic      reqPending,
  input  logic      delayDone,
  output dpStrobe_t strobe,
  output logic      memBusy
);

  seqState_e state, nextState;
  logic      isSelf, selfReq, grant;

  assign selfReq = refEnable & refMode;
  assign grant   = (state == ST_IDLE) && accessIdle && (selfReq || reqPending);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isSelf <= 1'b0;
    end else begin
      state <= nextState;
      if (grant) isSelf <= selfReq;
    end
  end

  always_comb begin
    nextState      = state;
    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    case (state)
      ST_IDLE: if (grant) begin
        strobe.takeReq = 1'b1;
        nextState      = ST_ARB;
      end
      ST_ARB: if (!bankBusy) nextState = ST_PALL;
      ST_PALL: begin
        strobe.cmd     = CMD_PALL;
        strobe.loadPre = 1'b1;
        nextState      = ST_TRP;
      end
      ST_TRP: if (delayDone) nextState = isSelf ? ST_SELF : ST_REF;
      ST_REF: begin
        strobe.cmd     = CMD_REF;
        strobe.loadRec = 1'b1;
        nextState      = ST_TRC;
      end
      ST_SELF: begin
        strobe.cmd    = CMD_REF;
        strobe.ckeLow = 1'b1;
        nextState     = ST_SR;
      end
      ST_SR: begin
        strobe.ckeLow = 1'b1;
        if (!refMode) begin
          strobe.loadRec = 1'b1;
          nextState      = ST_TRC;
        end
      end
      ST_TRC: if (delayDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign memBusy = (state != ST_IDLE);

  p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memBusy) |-> $past(accessIdle))
    else $error("bus claimed while access engine active");

  p_self_needs_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && $past(state) == ST_IDLE && isSelf) |-> $past(refMode && refEnable))
    else $error("self-refresh started without both controls");

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_refresh_pkg::*;
#(
  parameter int INTW = 16,
  parameter int TW   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refEnable,
  input  logic            refMode,
  input  logic [TW-1:0]   tPreSel,
  input  logic [TW-1:0]   tRecSel,
  input  logic [INTW-1:0] refInterval,
  input  logic            accessIdle,
  input  logic            bankBusy,
  output logic            csN,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic            addrA10,
  output logic            cke,
  output logic            memBusy
);

  dpStrobe_t strobe;
  logic      reqPending, delayDone;
  logic [3:0] pins;

  refresh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refEnable(refEnable), .refMode(refMode),
    .accessIdle(accessIdle), .bankBusy(bankBusy), .reqPending(reqPending),
    .delayDone(delayDone), .strobe(strobe), .memBusy(memBusy)
  );

  refresh_dp #(.INTW(INTW), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .refEnable(refEnable), .refMode(refMode),
    .tPreSel(tPreSel), .tRecSel(tRecSel), .refInterval(refInterval),
    .strobe(strobe), .reqPending(reqPending), .delayDone(delayDone),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addrA10(addrA10), .cke(cke)
  );

  assign pins = {csN, rasN, casN, weN};

  p_pall_bank_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pins == PIN_PALL) |-> !$past(bankBusy))
    else $error("precharge-all while a bank was busy");

  p_gap_before_refresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pins == PIN_REF) |-> ($past(pins) == PIN_NOP))
    else $error("refresh command without preceding idle gap");

  p_self_holds_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> memBusy)
    else $error("clock-enable low while bus released");

  p_wake_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (pins == PIN_NOP && memBusy))
    else $error("command issued on self-refresh exit");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !memBusy |-> (pins == PIN_NOP && cke))
    else $error("command issued while bus released");

endmodule

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int INTW = 16;
  localparam int IVL  = 20;
  localparam logic [3:0] E_NOP  = 4'b0111;
  localparam logic [3:0] E_PALL = 4'b0010;
  localparam logic [3:0] E_REF  = 4'b0001;

  logic clk, rstN, refEnable, refMode, accessIdle, bankBusy;
  logic [1:0] tPreSel, tRecSel;
  logic [INTW-1:0] refInterval;
  logic csN, rasN, casN, weN, addrA10, cke, memBusy;

  int nChecks = 0;
  int nFails  = 0;

  sdram_refresh_seq #(.INTW(INTW), .TW(2)) u0 (
    .clk(clk), .rstN(rstN), .refEnable(refEnable), .refMode(refMode),
    .tPreSel(tPreSel), .tRecSel(tRecSel), .refInterval(refInterval),
    .accessIdle(accessIdle), .bankBusy(bankBusy),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addrA10(addrA10),
    .cke(cke), .memBusy(memBusy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // packs {pins, a10, cke, busy}
  task automatic expectOut(input string req, input string what,
                           input logic [3:0] p, input logic k, input logic b);
    int act, exp;
    act = int'({csN, rasN, casN, weN, addrA10, cke, memBusy});
    exp = int'({p, (p == E_PALL), k, b});
    check(req, what, act, exp);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && memBusy; i++) tick();
  endtask

  task automatic t_reset();
    expectOut("R1", "reset outputs", E_NOP, 1'b1, 1'b0);
    tick();
    expectOut("R11", "idle after reset", E_NOP, 1'b1, 1'b0);
  endtask

  task automatic t_auto(input int tp, input int tr);
    int n;
    tPreSel = 2'(tp); tRecSel = 2'(tr);
    accessIdle = 1'b1; refMode = 1'b0; refEnable = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!memBusy && n < 200);
    check("R2", "cycles to first request", n, IVL + 1);
    expectOut("R3", "claim cycle", E_NOP, 1'b1, 1'b1);
    accessIdle = 1'b0;
    tick();
    expectOut("R1", "precharge-all code", E_PALL, 1'b1, 1'b1);
    for (int i = 0; i <= tp; i++) begin
      tick();
      expectOut("R5", "precharge gap", E_NOP, 1'b1, 1'b1);
    end
    tick();
    expectOut("R5", "auto-refresh after gap", E_REF, 1'b1, 1'b1);
    for (int i = 0; i <= tr; i++) begin
      tick();
      expectOut("R6", "refresh recovery", E_NOP, 1'b1, 1'b1);
    end
    tick();
    expectOut("R6", "bus released", E_NOP, 1'b1, 1'b0);
    refEnable = 1'b0;
    tick();
    expectOut("R11", "quiet when released", E_NOP, 1'b1, 1'b0);
  endtask

  task automatic t_defer();
    int bad;
    tPreSel = 2'd0; tRecSel = 2'd0;
    accessIdle = 1'b0; refMode = 1'b0; refEnable = 1'b1;
    bad = 0;
    for (int i = 0; i < IVL + 10; i++) begin
      tick();
      if (memBusy || {csN, rasN, casN, weN} != E_NOP) bad++;
    end
    check("R3", "no claim while access active", bad, 0);
    accessIdle = 1'b1;
    tick();
    expectOut("R3", "claim after idle", E_NOP, 1'b1, 1'b1);
    accessIdle = 1'b0;
    tick();
    expectOut("R3", "precharge after claim", E_PALL, 1'b1, 1'b1);
    waitIdle();
    refEnable = 1'b0;
    tick();
  endtask

  task automatic t_bank();
    tPreSel = 2'd1; tRecSel = 2'd1;
    bankBusy = 1'b1; accessIdle = 1'b1; refMode = 1'b0; refEnable = 1'b1;
    for (int i = 0; i < 200 && !memBusy; i++) tick();
    accessIdle = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      expectOut("R4", "held by busy bank", E_NOP, 1'b1, 1'b1);
    end
    bankBusy = 1'b0;
    tick();
    expectOut("R4", "precharge after bank free", E_PALL, 1'b1, 1'b1);
    waitIdle();
    refEnable = 1'b0;
    tick();
  endtask

  task automatic t_self(input int tp, input int tr, input bit keep);
    int n;
    tPreSel = 2'(tp); tRecSel = 2'(tr);
    accessIdle = 1'b1; refEnable = 1'b1; refMode = 1'b1;
    tick();
    expectOut("R7", "self claim", E_NOP, 1'b1, 1'b1);
    accessIdle = 1'b0;
    tick();
    expectOut("R7", "self precharge-all", E_PALL, 1'b1, 1'b1);
    for (int i = 0; i <= tp; i++) begin
      tick();
      expectOut("R5", "self precharge gap", E_NOP, 1'b1, 1'b1);
    end
    tick();
    expectOut("R1", "self entry code", E_REF, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      tick();
      expectOut("R8", "in self-refresh", E_NOP, 1'b0, 1'b1);
    end
    refMode = 1'b0;
    if (!keep) refEnable = 1'b0;
    tick();
    expectOut("R9", "exit raises cke", E_NOP, 1'b1, 1'b1);
    for (int i = 0; i < tr; i++) begin
      tick();
      expectOut("R9", "exit recovery", E_NOP, 1'b1, 1'b1);
    end
    tick();
    expectOut("R9", "released after exit", E_NOP, 1'b1, 1'b0);
    if (keep) begin
      accessIdle = 1'b1;
      n = 0;
      do begin tick(); n++; end while (!memBusy && n < 200);
      check("R10", "auto restart delay", n, IVL + 1 - tr - 2);
      accessIdle = 1'b0;
      tick();
      expectOut("R10", "auto restart precharge", E_PALL, 1'b1, 1'b1);
      waitIdle();
      refEnable = 1'b0;
      tick();
    end else begin
      int bad;
      accessIdle = 1'b1;
      bad = 0;
      for (int i = 0; i < 3 * IVL; i++) begin
        tick();
        if (memBusy) bad++;
      end
      check("R10", "no restart when disabled", bad, 0);
    end
  endtask

  task automatic t_modeOnly();
    int bad;
    refEnable = 1'b0; refMode = 1'b1; accessIdle = 1'b1;
    bad = 0;
    for (int i = 0; i < 3 * IVL; i++) begin
      tick();
      if (memBusy || !cke) bad++;
    end
    check("R7", "mode alone starts nothing", bad, 0);
    refMode = 1'b0;
    tick();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL all requirements: watchdog expired, actual hung expected done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; refEnable = 1'b0; refMode = 1'b0; accessIdle = 1'b0;
    bankBusy = 1'b0; tPreSel = 2'd0; tRecSel = 2'd0;
    refInterval = INTW'(IVL);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_auto(0, 0);
    t_auto(3, 2);
    t_auto(1, 3);
    t_defer();
    t_bank();
    t_self(2, 1, 1'b1);
    t_self(0, 3, 1'b0);
    t_modeOnly();
    finishRun();
  end

endmodule